// File: doc/BRIEF.md
# Key Matrix Scanner with Validation

This block sits at the front of an infrared remote-control transmitter and turns a key press into a code. It drives eight scan lines and reads two groups of active-low sense lines: eight command lines and four system lines. A key connects one sense line to one scan line. While the block waits for a press, it asserts every scan line at once, so any closed key pulls its sense line low. When exactly one sense line goes active, the block waits out a debounce interval. It then drops the all-asserted pattern and walks a single asserted scan line from index 0 upward, one slot per bit-time tick, to find which scan line the active sense line is wired to.

A command key gives a 6-bit code, and a system key gives a 5-bit code. In each code the sense-line index forms the upper bits and the scan-line index forms the lower bits. A configuration input selects one of two modes. In key mode, the system lines are ordinary keys. In strap mode, they are ignored as keys, and a fixed wire from one system line to one scan line supplies the system number during every scan.

When two or more sense lines are active together, no scan and no strobe take place until every key is released. The tick comes from an external timing block. Debounce and scan together last a set number of ticks.

Top module: `keypad_scan_top`

## Requirements
- R1: After reset, all scan outputs are asserted (`drv_en_n` all 0), `code_valid`, `key_is_sys` and `sys_ok` are 0, and `cmd_code` and `sys_code` are 0.
- R2: Outside a scan, all scan outputs are asserted together. A single key closing in this state starts a press cycle.
- R3: During the scan exactly one scan output is asserted. Index k is asserted from the (DEB_TICKS+k)-th tick after wake-up until the next tick, for k = 0 .. N_DRV-1 in ascending order.
- R4: A command key on sense line x and scan line d yields `cmd_code` = {x[2:0], d[2:0]} with `key_is_sys` = 0.
- R5: `code_valid` is a one-cycle pulse. With FRAME_TICKS = DEB_TICKS + N_DRV = 18, it is high in the second cycle after the clock edge that samples the 18th tick counted after wake-up.
- R6: Two or more key sense lines active at wake-up (command with command, or command with system in key mode) give no scan and no strobe, and they leave the code outputs unchanged.
- R7: If a sense line is wired to several scan lines, the highest scan index found in the scan forms the code.
- R8: In key mode (`strap_mode` = 0), a system key on line z and scan line d yields `sys_code` = {z[1:0], d[2:0]}, `key_is_sys` = 1 and `sys_ok` = 1, and leaves `cmd_code` unchanged.
- R9: In strap mode, system lines do not wake the block. A command press captures the strap from line z to scan line d as `sys_code` = {z, d} with `sys_ok` = 1.
- R10: In strap mode with no strap wired, a command press still strobes with the new `cmd_code`, but `sys_ok` = 0 and `sys_code` is unchanged.
- R11: If exactly one key is not active when the debounce interval ends, no scan and no strobe follow.
- R12: After a strobe, no further strobe occurs until all keys have been released, however long the key is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit time, at least 3 cycles apart |
| strap_mode | input | 1 | 1: system number from a fixed strap; 0: system lines act as keys |
| cmd_sense_n | input | 8 | Command sense lines, active low |
| sys_sense_n | input | 4 | System sense lines, active low |
| drv_en_n | output | 8 | Scan line enables, 0 = line pulled low |
| code_valid | output | 1 | One-cycle strobe: a legal key was found |
| key_is_sys | output | 1 | The strobed key was a system key |
| cmd_code | output | 6 | Command code {sense index, scan index} |
| sys_code | output | 5 | System code {sense index, scan index} |
| sys_ok | output | 1 | `sys_code` holds a produced system number |

## Verification
A control state that is stuck or skips ahead shows up at the scan outputs within one tick. The one-cold scan pattern appears early, late or out of order, or the all-asserted pattern fails to return. For this reason the scan lines are compared on every clock against a pattern predicted from the tick count since the press. A wrong capture register appears only at the strobe, as a wrong code or a wrong `sys_ok`. The strobe's timing is checked to the exact cycle. Presses that must be rejected (several keys, a bounce, a held key, a strap with no key) are checked by counting strobes over a window longer than a full press cycle.

// File: rtl/kms_pkg.sv
// Shared types for the key matrix scanner.
package kms_pkg;
    // Press-cycle phases of the scan controller.
    typedef enum logic [2:0] {
        ST_IDLE,      // all scan lines asserted, waiting for a key
        ST_DEBOUNCE,  // all scan lines asserted, counting debounce ticks
        ST_SCAN,      // one scan line asserted per tick slot
        ST_DECIDE,    // publish the result of the scan
        ST_RELEASE    // all scan lines asserted, waiting for release
    } scan_state_t;
endpackage

// File: rtl/kms_sync.sv
// Two-flop synchronizer for a bus of asynchronous sense inputs.
// Assumes each bit is independent; no multi-bit coherence is implied.
module kms_sync #(
    parameter int W       = 8,
    parameter bit RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] meta_q;

    // Two-stage capture; reset to the inactive level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= {W{RST_VAL}};
            dout   <= {W{RST_VAL}};
        end else begin
            meta_q <= din;
            dout   <= meta_q;
        end
    end
endmodule

// File: rtl/kms_line_enc.sv
// Counts active lines in a vector and encodes the highest active index.
// Purely combinational; `one` and `multi` are mutually exclusive.
module kms_line_enc #(
    parameter int W  = 8,
    parameter int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  act,
    output logic          one,
    output logic          multi,
    output logic [IW-1:0] idx
);
    localparam int CW = $clog2(W + 1);
    logic [CW-1:0] cnt;

    // Population count and highest-index encoder in one pass.
    always_comb begin
        cnt = '0;
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (act[i]) begin
                cnt = cnt + CW'(1);
                idx = IW'(i);
            end
        end
    end

    assign one   = (cnt == CW'(1));
    assign multi = (cnt > CW'(1));
endmodule

// File: rtl/kms_ctrl.sv
// Press-cycle controller: wake-up, debounce, ascending scan, result publish
// and release wait. Assumes bit_tick pulses are at least 3 clocks apart, so
// a scan pattern has passed the sense synchronizer before it is sampled.
// Key index layout: command lines first, then system lines.
module kms_ctrl
    import kms_pkg::*;
#(
    parameter int N_DRV     = 8,
    parameter int CMD_LINES = 8,
    parameter int SYS_LINES = 4,
    parameter int DEB_TICKS = 10,
    parameter int KIW       = $clog2(CMD_LINES + SYS_LINES),
    parameter int SIW_IN    = (SYS_LINES > 1) ? $clog2(SYS_LINES) : 1
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  bit_tick,
    input  logic                                  strap_mode,
    input  logic                                  key_one,
    input  logic                                  key_multi,
    input  logic [KIW-1:0]                        key_idx,
    input  logic                                  strap_one,
    input  logic                                  strap_multi,
    input  logic [SIW_IN-1:0]                     strap_idx,
    output logic [N_DRV-1:0]                      drv_en_n,
    output logic                                  code_valid,
    output logic                                  key_is_sys,
    output logic [$clog2(CMD_LINES)+$clog2(N_DRV)-1:0] cmd_code,
    output logic [SIW_IN+$clog2(N_DRV)-1:0]       sys_code,
    output logic                                  sys_ok
);
    localparam int DIW     = $clog2(N_DRV);
    localparam int CIW     = $clog2(CMD_LINES);
    localparam int CNT_MAX = (DEB_TICKS > N_DRV) ? DEB_TICKS : N_DRV;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    scan_state_t        state;
    logic [CNT_W-1:0]   tick_cnt;
    logic               key_any, strap_any;
    logic               deb_last, scan_last;
    logic               found, found_bad;
    logic [KIW-1:0]     hit_idx;
    logic [DIW-1:0]     hit_drv;
    logic               strap_seen, strap_bad;
    logic [SIW_IN-1:0]  strap_z;
    logic [DIW-1:0]     strap_drv;
    logic [SIW_IN-1:0]  sys_off;

    assign key_any   = key_one | key_multi;
    assign strap_any = strap_one | strap_multi;
    assign deb_last  = (tick_cnt == CNT_W'(DEB_TICKS - 1));
    assign scan_last = (tick_cnt == CNT_W'(N_DRV - 1));
    assign sys_off   = SIW_IN'(hit_idx - KIW'(CMD_LINES));

    // Phase sequencing and the shared debounce / scan-slot counter (R2, R3, R6, R11, R12).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            tick_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    tick_cnt <= '0;
                    if (key_multi)    state <= ST_RELEASE;
                    else if (key_one) state <= ST_DEBOUNCE;
                end
                ST_DEBOUNCE: if (bit_tick) begin
                    if (deb_last) begin
                        tick_cnt <= '0;
                        state    <= key_one ? ST_SCAN : ST_RELEASE;
                    end else begin
                        tick_cnt <= tick_cnt + CNT_W'(1);
                    end
                end
                ST_SCAN: if (bit_tick) begin
                    if (scan_last) begin
                        tick_cnt <= '0;
                        state    <= ST_DECIDE;
                    end else begin
                        tick_cnt <= tick_cnt + CNT_W'(1);
                    end
                end
                ST_DECIDE: state <= ST_RELEASE;
                ST_RELEASE: if (bit_tick && !key_any) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Scan line enables: one-cold slot during the scan, all asserted otherwise (R2, R3).
    for (genvar g = 0; g < N_DRV; g++) begin : g_drv
        assign drv_en_n[g] = (state == ST_SCAN) && (tick_cnt != CNT_W'(g));
    end

    // Per-slot capture; a later slot with activity overrides earlier ones (R7, R9).
    always_ff @(posedge clk) begin
        if (!rst_n || state == ST_DEBOUNCE) begin
            found      <= 1'b0;
            found_bad  <= 1'b0;
            hit_idx    <= '0;
            hit_drv    <= '0;
            strap_seen <= 1'b0;
            strap_bad  <= 1'b0;
            strap_z    <= '0;
            strap_drv  <= '0;
        end else if (state == ST_SCAN && bit_tick) begin
            if (key_any) begin
                found     <= 1'b1;
                found_bad <= key_multi;
                if (key_one) begin
                    hit_idx <= key_idx;
                    hit_drv <= tick_cnt[DIW-1:0];
                end
            end
            if (strap_mode && strap_any) begin
                strap_seen <= 1'b1;
                strap_bad  <= strap_multi;
                if (strap_one) begin
                    strap_z   <= strap_idx;
                    strap_drv <= tick_cnt[DIW-1:0];
                end
            end
        end
    end

    // Result publish: strobe and code registers, loaded once per legal scan (R4, R5, R8, R9, R10).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_valid <= 1'b0;
            key_is_sys <= 1'b0;
            cmd_code   <= '0;
            sys_code   <= '0;
            sys_ok     <= 1'b0;
        end else begin
            code_valid <= 1'b0;
            if (state == ST_DECIDE && found && !found_bad) begin
                code_valid <= 1'b1;
                if (hit_idx >= KIW'(CMD_LINES)) begin
                    key_is_sys <= 1'b1;
                    sys_code   <= {sys_off, hit_drv};
                    sys_ok     <= 1'b1;
                end else begin
                    key_is_sys <= 1'b0;
                    cmd_code   <= {hit_idx[CIW-1:0], hit_drv};
                    if (strap_mode) begin
                        sys_ok <= strap_seen && !strap_bad;
                        if (strap_seen && !strap_bad) sys_code <= {strap_z, strap_drv};
                    end
                end
            end
        end
    end

    AST_STROBE_DRIVERS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |-> (drv_en_n == '0)); // R2
    AST_SCAN_ONE_COLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN) |-> ($countones(drv_en_n) == N_DRV - 1)); // R3
    AST_SLOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN && !bit_tick) |=> $stable(drv_en_n)); // R3
    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |=> !code_valid); // R5
    AST_STROBE_AFTER_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |-> ($past(state) == ST_DECIDE)); // R5
    AST_MULTI_NO_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && key_multi) |=> (drv_en_n == '0)); // R6
    AST_RELEASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_RELEASE && state == ST_RELEASE) |-> !code_valid); // R12
endmodule

// File: rtl/keypad_scan_top.sv
// Key matrix scanner top: synchronizes the sense lines, forms the key and
// strap vectors for the selected system mode, and runs the press controller.
// Assumes strap_mode is static configuration and bit_tick pulses are at
// least 3 clocks apart. FRAME_TICKS must exceed N_DRV.
module keypad_scan_top #(
    parameter int N_DRV       = 8,
    parameter int CMD_LINES   = 8,
    parameter int SYS_LINES   = 4,
    parameter int FRAME_TICKS = 18
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       bit_tick,
    input  logic                                       strap_mode,
    input  logic [CMD_LINES-1:0]                       cmd_sense_n,
    input  logic [SYS_LINES-1:0]                       sys_sense_n,
    output logic [N_DRV-1:0]                           drv_en_n,
    output logic                                       code_valid,
    output logic                                       key_is_sys,
    output logic [$clog2(CMD_LINES)+$clog2(N_DRV)-1:0] cmd_code,
    output logic [$clog2(SYS_LINES)+$clog2(N_DRV)-1:0] sys_code,
    output logic                                       sys_ok
);
    localparam int DEB_TICKS = FRAME_TICKS - N_DRV;
    localparam int KEY_W     = CMD_LINES + SYS_LINES;
    localparam int KIW       = $clog2(KEY_W);
    localparam int SIW       = $clog2(SYS_LINES);

    logic [CMD_LINES-1:0] cmd_s_n;
    logic [SYS_LINES-1:0] sys_s_n;
    logic [KEY_W-1:0]     key_vec;
    logic [SYS_LINES-1:0] strap_vec;
    logic                 key_one, key_multi, strap_one, strap_multi;
    logic [KIW-1:0]       key_idx;
    logic [SIW-1:0]       strap_idx;

    kms_sync #(.W(CMD_LINES), .RST_VAL(1'b1)) u_sync_cmd (
        .clk(clk), .rst_n(rst_n), .din(cmd_sense_n), .dout(cmd_s_n));
    kms_sync #(.W(SYS_LINES), .RST_VAL(1'b1)) u_sync_sys (
        .clk(clk), .rst_n(rst_n), .din(sys_sense_n), .dout(sys_s_n));

    // System lines count as keys only in key mode; in strap mode they feed the strap encoder (R8, R9).
    assign key_vec   = {~sys_s_n & {SYS_LINES{~strap_mode}}, ~cmd_s_n};
    assign strap_vec = ~sys_s_n & {SYS_LINES{strap_mode}};

    kms_line_enc #(.W(KEY_W), .IW(KIW)) u_enc_key (
        .act(key_vec), .one(key_one), .multi(key_multi), .idx(key_idx));
    kms_line_enc #(.W(SYS_LINES), .IW(SIW)) u_enc_strap (
        .act(strap_vec), .one(strap_one), .multi(strap_multi), .idx(strap_idx));

    kms_ctrl #(
        .N_DRV(N_DRV), .CMD_LINES(CMD_LINES), .SYS_LINES(SYS_LINES),
        .DEB_TICKS(DEB_TICKS), .KIW(KIW), .SIW_IN(SIW)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .strap_mode(strap_mode),
        .key_one(key_one), .key_multi(key_multi), .key_idx(key_idx),
        .strap_one(strap_one), .strap_multi(strap_multi), .strap_idx(strap_idx),
        .drv_en_n(drv_en_n), .code_valid(code_valid), .key_is_sys(key_is_sys),
        .cmd_code(cmd_code), .sys_code(sys_code), .sys_ok(sys_ok));

    AST_CODE_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmd_code) |-> code_valid); // R6
endmodule

// File: tb/keypad_scan_top_tb_top.sv
module keypad_scan_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TDIV       = 4;
    localparam int NDRV       = 8;
    localparam int DEB        = 10;
    localparam int WD_LIMIT   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       strap_mode = 1'b0;
    logic [7:0] cmd_sense_n;
    logic [3:0] sys_sense_n;
    logic [7:0] drv_en_n;
    logic       code_valid, key_is_sys, sys_ok;
    logic [5:0] cmd_code;
    logic [4:0] sys_code;

    logic [7:0] cmd_conn [8];
    logic [7:0] sys_conn [4];

    int cyc = 0;
    int compared = 0;
    int mismatched = 0;
    int strobes = 0;
    int exp_scan = -1;
    int exp_stb = -1;
    bit done = 1'b0;

    keypad_scan_top dut_i (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .strap_mode(strap_mode),
        .cmd_sense_n(cmd_sense_n), .sys_sense_n(sys_sense_n), .drv_en_n(drv_en_n),
        .code_valid(code_valid), .key_is_sys(key_is_sys), .cmd_code(cmd_code),
        .sys_code(sys_code), .sys_ok(sys_ok));

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Key matrix model: a sense line is low when any scan line it touches is asserted.
    always_comb begin
        for (int x = 0; x < 8; x++) cmd_sense_n[x] = ~|(cmd_conn[x] & ~drv_en_n);
        for (int z = 0; z < 4; z++) sys_sense_n[z] = ~|(sys_conn[z] & ~drv_en_n);
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // Per-clock reference: scan pattern and strobe predicted from the tick schedule.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit exp_v;
            logic [7:0] exp_d;
            bit in_scan;
            exp_v   = (cyc == exp_stb);
            in_scan = (exp_scan >= 0) && (cyc >= exp_scan) && (cyc < exp_scan + NDRV*TDIV);
            exp_d   = in_scan ? ~(8'(1) << ((cyc - exp_scan) / TDIV)) : 8'h00;
            if (code_valid) strobes++;
            chk("R5", "code_valid", int'(code_valid), int'(exp_v));
            chk(in_scan ? "R3" : "R2", "drv_en_n", int'(drv_en_n), int'(exp_d));
        end
        bit_tick = ((cyc + 1) % TDIV == 0);
    end

    // Watchdog: a hung run is one failed check and still reaches the summary.
    always @(posedge clk) begin
        if (cyc == WD_LIMIT && !done) begin
            done = 1'b1;
            mismatched++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic clear_keys();
        for (int x = 0; x < 8; x++) cmd_conn[x] = 8'h00;
        for (int z = 0; z < 4; z++) sys_conn[z] = 8'h00;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Called right after keys change at a negedge: predicts scan start and strobe cycle.
    task automatic arm(input bit will_strobe);
        int e0;
        e0 = cyc + 4;
        while (e0 % TDIV != 0) e0++;
        if (will_strobe) begin
            exp_scan = e0 + (DEB - 1) * TDIV;
            exp_stb  = exp_scan + NDRV * TDIV + 1;
        end else begin
            exp_scan = -1;
            exp_stb  = -1;
        end
    endtask

    task automatic wait_strobe();
        while (cyc < exp_stb) @(negedge clk);
    endtask

    task automatic release_all();
        clear_keys();
        wait_cyc(3);
        exp_scan = -1;
        exp_stb  = -1;
        wait_cyc(16);
    endtask

    initial begin
        int s0;
        clear_keys();
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(1);
        // R1 reset state
        chk("R1", "drv_en_n", int'(drv_en_n), 0);
        chk("R1", "code_valid", int'(code_valid), 0);
        chk("R1", "cmd_code", int'(cmd_code), 0);
        chk("R1", "sys_code", int'(sys_code), 0);
        chk("R1", "sys_ok", int'(sys_ok), 0);
        chk("R1", "key_is_sys", int'(key_is_sys), 0);
        wait_cyc(5);

        // R4 / R2: command key X5 on DR2 -> 42
        cmd_conn[5] = 8'h04; arm(1'b1); wait_strobe();
        chk("R4", "cmd_code", int'(cmd_code), 42);
        chk("R4", "key_is_sys", int'(key_is_sys), 0);
        release_all();

        // R4: corners X0/DR7 -> 7 and X7/DR0 -> 56
        cmd_conn[0] = 8'h80; arm(1'b1); wait_strobe();
        chk("R4", "cmd_code", int'(cmd_code), 7);
        release_all();
        cmd_conn[7] = 8'h01; arm(1'b1); wait_strobe();
        chk("R4", "cmd_code", int'(cmd_code), 56);
        release_all();

        // R7: X3 wired to DR1 and DR6 -> highest scan index wins -> 30
        cmd_conn[3] = 8'h42; arm(1'b1); wait_strobe();
        chk("R7", "cmd_code", int'(cmd_code), 30);
        release_all();

        // R8: key-mode system key Z2 on DR5 -> 21
        sys_conn[2] = 8'h20; arm(1'b1); wait_strobe();
        chk("R8", "sys_code", int'(sys_code), 21);
        chk("R8", "key_is_sys", int'(key_is_sys), 1);
        chk("R8", "sys_ok", int'(sys_ok), 1);
        chk("R8", "cmd_code unchanged", int'(cmd_code), 30);
        release_all();

        // R6: two command keys -> no scan, no strobe, codes unchanged
        s0 = strobes;
        cmd_conn[1] = 8'h01; cmd_conn[4] = 8'h04; arm(1'b0);
        wait_cyc(120);
        chk("R6", "strobes (X+X)", strobes - s0, 0);
        chk("R6", "cmd_code", int'(cmd_code), 30);
        release_all();
        s0 = strobes;
        cmd_conn[2] = 8'h08; sys_conn[0] = 8'h10; arm(1'b0);
        wait_cyc(120);
        chk("R6", "strobes (X+Z)", strobes - s0, 0);
        chk("R6", "sys_code", int'(sys_code), 21);
        release_all();

        // R11: key bounces open before debounce ends
        s0 = strobes;
        cmd_conn[6] = 8'h08; arm(1'b0);
        wait_cyc(8);
        clear_keys();
        wait_cyc(120);
        chk("R11", "strobes after bounce", strobes - s0, 0);
        release_all();

        // R12: long hold gives exactly one strobe
        s0 = strobes;
        cmd_conn[4] = 8'h02; arm(1'b1); wait_strobe();
        chk("R4", "cmd_code", int'(cmd_code), 33);
        wait_cyc(200);
        chk("R12", "strobes while held", strobes - s0, 1);
        release_all();

        // R9: strap mode, strap Z1 -> DR3 alone does not wake
        strap_mode = 1'b1;
        wait_cyc(2);
        s0 = strobes;
        sys_conn[1] = 8'h08;
        wait_cyc(120);
        chk("R9", "strobes from strap alone", strobes - s0, 0);
        // R9: X6 on DR4 with strap -> cmd 52, sys 11
        cmd_conn[6] = 8'h10; arm(1'b1); wait_strobe();
        chk("R9", "cmd_code", int'(cmd_code), 52);
        chk("R9", "sys_code", int'(sys_code), 11);
        chk("R9", "sys_ok", int'(sys_ok), 1);
        cmd_conn[6] = 8'h00;
        wait_cyc(3);
        exp_scan = -1; exp_stb = -1;
        wait_cyc(16);

        // R10: strap removed, X2 on DR1 -> cmd 17, sys_ok 0, sys_code held
        sys_conn[1] = 8'h00;
        wait_cyc(4);
        cmd_conn[2] = 8'h02; arm(1'b1); wait_strobe();
        chk("R10", "code_valid", int'(code_valid), 1);
        chk("R10", "cmd_code", int'(cmd_code), 17);
        chk("R10", "sys_ok", int'(sys_ok), 0);
        chk("R10", "sys_code", int'(sys_code), 11);
        release_all();
        strap_mode = 1'b0;
        wait_cyc(8);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule